// File: doc/BRIEF.md
# Escape Sequence Character Detector

This block watches the byte stream coming out of a serial receiver, together with a tick that marks each bit period, and recognises an escape sequence. The sequence is one programmed character sent several times in a row and framed by silence on both sides, in the way a modem recognises a "+++" escape. The block is placed beside the receiver. It takes the receiver's byte strobe and data, the bit-period tick and a set of static configuration fields. When it sees a valid sequence it raises a single-cycle request on a fixed bit of an interrupt vector.

Silence is measured as the number of bit-period ticks since the most recent received byte. The counter saturates and is cleared by every byte. A sequence opens only on a matching byte that arrives after at least the pre-idle time of silence. The sequence grows while matching bytes keep arriving inside the gap limit. It is reported once the line has then stayed silent for the post-idle time, provided enough matching bytes have been collected.

Top module: `escdet_top`

## Requirements
- R1: After reset the interrupt vector is all zero, and the silence count starts at zero, so pre-idle is counted from reset.
- R2: Only bytes equal to `cfgChar` count toward a sequence. A different byte in the middle of a sequence discards it and clears the silence count, so a new sequence needs a full pre-idle again.
- R3: A detection needs at least `cfgCount` matching bytes. With fewer there is no detection. With more there is exactly one detection.
- R4: Until the count is met, each further matching byte must arrive while the silence count is below `cfgGap`. When the count reaches `cfgGap` the sequence is dropped, and a byte after that is judged only as a possible first byte.
- R5: The first matching byte is accepted only if the silence count at its arrival is at least `cfgPre` ticks.
- R6: With the count met, the silence count reaching `cfgPost` raises bit 18 of `irqVec` for exactly one clock. The bit rises on the clock edge after the edge that registers the `cfgPost`-th tick. All other bits of `irqVec` stay 0.
- R7: A byte that arrives while the post-idle window is running has priority over detection, even in the cycle the window completes. A matching byte extends the sequence and restarts the window. Any other byte cancels the pending detection.
- R8: The silence count saturates at its all-ones value. A pre-idle setting equal to that maximum is therefore still satisfied after a longer silence.
- R9: A `cfgCount` of 0 or 1 makes a single matching byte, framed by pre-idle and post-idle, a complete sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxValid | input | 1 | One-cycle strobe for a received byte |
| rxData | input | DW (8) | Received byte |
| bitTick | input | 1 | One pulse per bit period |
| cfgChar | input | DW (8) | Escape character to match |
| cfgCount | input | CW (4) | Minimum number of matching bytes |
| cfgGap | input | TW (8) | Gap limit between matching bytes, in ticks |
| cfgPre | input | TW (8) | Silence required before the first byte, in ticks |
| cfgPost | input | TW (8) | Silence required after the last byte, in ticks |
| irqVec | output | IW (20) | Interrupt vector; bit 18 is the detection pulse |

## Verification
Two functions can fall in the same cycle: the post-idle window completing and a new byte arriving. The bench provokes this by asserting `rxValid` in the cycle right after the `cfgPost`-th tick is registered. It does this once with a foreign byte, where no pulse may follow, and once with the escape character, where a single later pulse must follow a fresh post window. A second such coincidence is a late matching byte that arrives just as the gap limit is reached. This is judged against the one-tick-earlier case, which must be accepted.

// File: rtl/escdet_pkg.sv
package escdet_pkg;
  localparam int CMD_IRQ_BIT = 18;

  typedef enum logic {ST_WAIT, ST_COLL} escState_t;

  // control -> datapath
  typedef struct packed {
    logic cntStart;
    logic cntInc;
    logic cntClr;
    logic fire;
  } escStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic isMatch;
    logic gePre;
    logic geGap;
    logic gePost;
    logic cntMet;
  } escStatus_t;
endpackage

// File: rtl/escdet_dp.sv
module escdet_dp
  import escdet_pkg::*;
#(
  parameter int DW = 8,
  parameter int TW = 8,
  parameter int CW = 4,
  parameter int IW = 20
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxValid,
  input  logic [DW-1:0] rxData,
  input  logic          bitTick,
  input  logic [DW-1:0] cfgChar,
  input  logic [CW-1:0] cfgCount,
  input  logic [TW-1:0] cfgGap,
  input  logic [TW-1:0] cfgPre,
  input  logic [TW-1:0] cfgPost,
  input  escStrobe_t    stb,
  output escStatus_t    sts,
  output logic [TW-1:0] idleCnt,
  output logic [IW-1:0] irqVec
);
  localparam logic [TW-1:0] IDLE_MAX = {TW{1'b1}};
  localparam logic [CW-1:0] CNT_MAX  = {CW{1'b1}};

  logic [CW-1:0] matchCnt;
  logic          pulse;

  // silence counter, in bit periods, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              idleCnt <= '0;
    else if (rxValid)                       idleCnt <= '0;
    else if (bitTick && idleCnt != IDLE_MAX) idleCnt <= idleCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             matchCnt <= '0;
    else if (stb.cntClr)   matchCnt <= '0;
    else if (stb.cntStart) matchCnt <= {{(CW-1){1'b0}}, 1'b1};
    else if (stb.cntInc && matchCnt != CNT_MAX) matchCnt <= matchCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulse <= 1'b0;
    else       pulse <= stb.fire;
  end

  always_comb begin
    sts.isMatch = (rxData == cfgChar);
    sts.gePre   = (idleCnt >= cfgPre);
    sts.geGap   = (idleCnt >= cfgGap);
    sts.gePost  = (idleCnt >= cfgPost);
    sts.cntMet  = (matchCnt >= cfgCount);
  end

  for (genvar i = 0; i < IW; i++) begin : g_irq
    if (i == CMD_IRQ_BIT) begin : g_cmd
      assign irqVec[i] = pulse;
    end else begin : g_zero
      assign irqVec[i] = 1'b0;
    end
  end
endmodule

// File: rtl/escdet_ctrl.sv
module escdet_ctrl
  import escdet_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  escStatus_t sts,
  output escStrobe_t stb
);
  escState_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_WAIT;
    else       state <= nxt;
  end

  always_comb begin
    stb = '0;
    nxt = state;
    unique case (state)
      ST_WAIT: begin
        if (rxValid && sts.isMatch && sts.gePre) begin
          stb.cntStart = 1'b1;
          nxt          = ST_COLL;
        end
      end
      ST_COLL: begin
        if (rxValid) begin
          if (sts.isMatch && (sts.cntMet || !sts.geGap)) begin
            stb.cntInc = 1'b1;          // extends sequence (also in post window)
          end else if (sts.isMatch && sts.gePre) begin
            stb.cntStart = 1'b1;        // late byte reopens a sequence
          end else begin
            stb.cntClr = 1'b1;
            nxt        = ST_WAIT;
          end
        end else if (sts.cntMet && sts.gePost) begin
          stb.fire   = 1'b1;
          stb.cntClr = 1'b1;
          nxt        = ST_WAIT;
        end else if (!sts.cntMet && sts.geGap) begin
          stb.cntClr = 1'b1;
          nxt        = ST_WAIT;
        end
      end
      default: nxt = ST_WAIT;
    endcase
  end
endmodule

// File: rtl/escdet_top.sv
module escdet_top
  import escdet_pkg::*;
#(
  parameter int DW = 8,
  parameter int TW = 8,
  parameter int CW = 4,
  parameter int IW = 20
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxValid,
  input  logic [DW-1:0] rxData,
  input  logic          bitTick,
  input  logic [DW-1:0] cfgChar,
  input  logic [CW-1:0] cfgCount,
  input  logic [TW-1:0] cfgGap,
  input  logic [TW-1:0] cfgPre,
  input  logic [TW-1:0] cfgPost,
  output logic [IW-1:0] irqVec
);
  escStrobe_t    stb;
  escStatus_t    sts;
  logic [TW-1:0] idleCnt;

  escdet_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .sts(sts), .stb(stb)
  );

  escdet_dp #(.DW(DW), .TW(TW), .CW(CW), .IW(IW)) u_dp (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .bitTick(bitTick), .cfgChar(cfgChar), .cfgCount(cfgCount),
    .cfgGap(cfgGap), .cfgPre(cfgPre), .cfgPost(cfgPost),
    .stb(stb), .sts(sts), .idleCnt(idleCnt), .irqVec(irqVec)
  );
endmodule

// File: rtl/escdet_chk.sv
module escdet_chk #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          rxValid,
  input logic          bitTick,
  input logic          pulse,
  input logic [TW-1:0] idleCnt,
  input logic [TW-1:0] cfgPost
);
  localparam logic [TW-1:0] IDLE_MAX = {TW{1'b1}};

  assert_single_cycle_R6: assert property (@(posedge clk) disable iff (!rstN)
    pulse |=> !pulse);

  assert_post_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    pulse |-> ($past(idleCnt) >= $past(cfgPost)));

  assert_byte_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !pulse);

  assert_clear_on_byte_R2: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> (idleCnt == '0));

  assert_tick_counts_R8: assert property (@(posedge clk) disable iff (!rstN)
    (bitTick && !rxValid && idleCnt != IDLE_MAX) |=> (idleCnt == TW'($past(idleCnt) + 1'b1)));

  assert_saturate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!rxValid && idleCnt == IDLE_MAX) |=> (idleCnt == IDLE_MAX));
endmodule

bind escdet_top escdet_chk #(.TW(TW)) u_chk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .bitTick(bitTick),
  .pulse(irqVec[escdet_pkg::CMD_IRQ_BIT]), .idleCnt(idleCnt), .cfgPost(cfgPost)
);

// File: tb/escdet_top_bench.sv
`timescale 1ns/1ps
module escdet_top_bench;
  localparam int DW = 8, TW = 8, CW = 4, IW = 20, BIT = 18;

  logic clk = 0, rstN = 0, rxValid = 0, bitTick = 0;
  logic [DW-1:0] rxData = '0, cfgChar = 8'h2B;
  logic [CW-1:0] cfgCount = 4'd3;
  logic [TW-1:0] cfgGap = 8'd10, cfgPre = 8'd20, cfgPost = 8'd20;
  logic [IW-1:0] irqVec;

  int checks = 0, fails = 0, pulses = 0, mark = 0;
  int expQ[$];
  string reqQ[$];
  bit prevPulse = 0;

  always #5 clk = ~clk;

  escdet_top #(.DW(DW), .TW(TW), .CW(CW), .IW(IW)) u_escdet_top (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .bitTick(bitTick), .cfgChar(cfgChar), .cfgCount(cfgCount),
    .cfgGap(cfgGap), .cfgPre(cfgPre), .cfgPost(cfgPost), .irqVec(irqVec)
  );

  // monitor: counts pulses, checks width and unused bits (R6)
  always @(negedge clk) if (rstN) begin
    if (irqVec[BIT]) pulses++;
    if ((irqVec & ~(20'd1 << BIT)) != 0) begin
      fails++; $display("FAIL R6 other irq bits actual=%h expected=0", irqVec);
    end
    if (irqVec[BIT] && prevPulse) begin
      fails++; $display("FAIL R6 pulse longer than one cycle actual=2 expected=1");
    end
    prevPulse = irqVec[BIT];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    bitTick = 1;
    repeat (n) @(negedge clk);
    bitTick = 0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    rxData = b; rxValid = 1;
    @(negedge clk);
    rxValid = 0;
  endtask

  // driver: opens a scenario, pushes its expectation
  task automatic openScen(input int expN, input string req);
    mark = pulses;
    expQ.push_back(expN);
    reqQ.push_back(req);
    sendByte("A");                 // foreign byte: resets silence
  endtask

  // scoreboard side: let the line go quiet, pop and compare
  task automatic closeScen();
    int e; string r;
    tick(60);
    repeat (3) @(negedge clk);
    e = expQ.pop_front();
    r = reqQ.pop_front();
    chk((pulses - mark) == e, r, pulses - mark, e);
  endtask

  task automatic plusN(input int n, input int gapTicks);
    for (int i = 0; i < n; i++) begin
      sendByte("+");
      if (i != n - 1) tick(gapTicks);
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(irqVec == 0, "R1 reset irq", int'(irqVec), 0);
    rstN = 1;
    @(negedge clk);
    chk(irqVec == 0, "R1 irq after reset", int'(irqVec), 0);

    // R1: pre-idle counted from reset; R6 exact timing
    tick(20);
    plusN(3, 3);
    tick(20);
    chk(irqVec[BIT] == 0, "R6 no pulse at post edge", irqVec[BIT], 0);
    @(negedge clk);
    chk(irqVec[BIT] == 1, "R6 pulse one edge later", irqVec[BIT], 1);
    @(negedge clk);
    chk(irqVec[BIT] == 0, "R6 pulse ends", irqVec[BIT], 0);

    // R3 too few / more than enough
    openScen(0, "R3 two of three"); tick(20); plusN(2, 3); closeScen();
    openScen(1, "R3 five of three"); tick(20); plusN(5, 3); closeScen();

    // R2 foreign byte mid-sequence
    openScen(0, "R2 foreign byte breaks");
    tick(20); plusN(2, 2); sendByte("A"); plusN(2, 2); closeScen();
    openScen(0, "R2 wrong character");
    tick(20); cfgChar = 8'h2A; plusN(3, 2); closeScen();
    cfgChar = 8'h2B;

    // R4 gap boundary
    openScen(1, "R4 gap 9 accepted"); tick(20); plusN(3, 9); closeScen();
    openScen(0, "R4 gap 10 dropped"); tick(20); plusN(3, 10); closeScen();

    // R5 pre-idle boundary
    openScen(0, "R5 pre 19 rejected"); tick(19); plusN(3, 3); closeScen();
    openScen(1, "R5 pre 20 accepted"); tick(20); plusN(3, 3); closeScen();

    // R7 byte in the cycle the post window completes
    openScen(0, "R7 foreign byte cancels");
    tick(20); plusN(3, 3); tick(20); sendByte("A"); closeScen();
    openScen(1, "R7 matching byte extends");
    tick(20); plusN(3, 3); tick(20); sendByte("+"); closeScen();

    // R8 saturation with maximal pre-idle
    cfgPre = 8'd255;
    openScen(0, "R8 pre 254 of 255"); tick(254); plusN(3, 3); closeScen();
    openScen(1, "R8 saturated silence"); tick(300); plusN(3, 3); closeScen();
    cfgPre = 8'd20;

    // R9 single-byte sequences
    cfgCount = 4'd1;
    openScen(1, "R9 count one"); tick(20); plusN(1, 0); closeScen();
    cfgCount = 4'd0;
    openScen(1, "R9 count zero"); tick(20); plusN(1, 0); closeScen();
    cfgCount = 4'd3;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule